// File: doc/BRIEF.md
# Segmented Cross-Lane Shuffle Unit

This unit moves 32-bit words between the 32 lanes of a SIMD vector. Every lane presents one word. One shared mode, one shared 5-bit operand and one shared segment-width code apply to all lanes in the same transfer. The vector is cut into equal, aligned segments of 2, 4, 8, 16 or 32 lanes. Each lane works out a source lane from its own index, the mode and the operand. If that source lies inside the lane's own segment, the lane returns the source lane's word and raises its per-lane valid flag. If it does not, the lane keeps its own word and clears the flag.

The result is held in a single register stage with a valid/ready handshake. The input side is ready exactly when the output side is ready, so a transfer is taken in every cycle in which both in_valid and out_ready are high. The captured result appears one cycle later. Lane l occupies bits [32*l+31 : 32*l] of the wide data buses.

Top module: `lane_shuffle_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid is cleared. After reset, out_valid stays 0 until the first transfer is accepted.
- R2: in_ready always equals out_ready. A transfer is captured at a rising edge where in_valid and out_ready are both 1, and out_valid is 1 in the following cycle. When out_ready is 0, out_valid, data_out and lane_ok keep their values. When out_ready is 1 and in_valid is 0, out_valid is 0 after the edge.
- R3: mode_sel = 0 (up): the source of lane l is l minus operand.
- R4: mode_sel = 1 (down): the source of lane l is l plus operand.
- R5: mode_sel = 2 (xor): the source of lane l is l XOR operand.
- R6: mode_sel = 3 (indexed): the source of lane l is the first lane of l's segment plus operand.
- R7: A segment of width w covers lanes s to s+w-1, where s is l with its low log2(w) bits cleared. If the source of lane l is below 0, above 31, or outside that range, then lane_ok[l] is 0 and lane l returns its own input word. Otherwise lane_ok[l] is 1 and lane l returns the source lane's word.
- R8: width_sel codes 1, 2, 3, 4 and 5 select segment widths 2, 4, 8, 16 and 32. The codes 0, 6 and 7 select width 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A transfer is offered |
| in_ready | output | 1 | The unit can take a transfer; equals out_ready |
| mode_sel | input | 2 | 0 up, 1 down, 2 xor, 3 indexed |
| width_sel | input | 3 | Segment width code |
| operand | input | 5 | Shared delta, mask or in-segment index |
| data_in | input | 1024 | One 32-bit word per lane |
| out_valid | output | 1 | The registered result is present |
| out_ready | input | 1 | The consumer takes the result |
| data_out | output | 1024 | Shuffled word per lane |
| lane_ok | output | 32 | Per-lane flag: the source lay inside the segment |

## Verification
The clocked properties take for granted that rst_n is held low across at least one rising edge before anything else happens. They also assume that mode_sel, width_sel, operand and data_in are stable, 2-state values whenever in_valid and out_ready are both high, so that the value of $past at the capture edge is the word that was offered. The bench drives every input only at falling edges from known values and never leaves an input undriven. It holds reset for several edges, then walks every mode against every width code (illegal codes included) with edge operands before a long stretch of random transfers with random stalls.

// File: rtl/shuf_pkg.sv
// Package: shared constants and the mode encoding of the shuffle unit.
// Assumes a power-of-two lane count.
package shuf_pkg;

    parameter int unsigned LANES   = 32;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned WCODE_W = 3;
    localparam int unsigned IDX_W  = $clog2(LANES);

    // Mode encoding, as the shared mode_sel port carries it.
    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_XOR  = 2'd2,
        MODE_IDX  = 2'd3
    } shuf_mode_e;

endpackage

// File: rtl/shuf_width_decode.sv
// Module: turns the segment-width code into a mask of in-segment index bits.
// Code c in 1..IDX_W gives width 2**c, that is mask (2**c)-1. Any other
// code gives the full vector (all mask bits set).
// Assumes WCODE_W is wide enough to hold IDX_W.
module shuf_width_decode #(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned WCODE_W = 3
) (
    input  logic [WCODE_W-1:0] width_code,
    output logic [IDX_W-1:0]   seg_mask
);

    // Compare the code against each legal value; otherwise fall back to full width.
    always_comb begin
        seg_mask = '1;
        for (int c = 1; c <= IDX_W; c++) begin
            if (width_code == WCODE_W'(c)) begin
                seg_mask = IDX_W'((1 << c) - 1);
            end
        end
    end

endmodule

// File: rtl/shuf_lane_src.sv
// Module: source-lane computation and segment check for one lane.
// A (IDX_W+1)-bit sum keeps the borrow or carry out of the lane range, so
// underflow and overflow show as the top bit. The in-range result must
// share its upper (segment) bits with the lane's own index.
// Assumes seg_mask is a contiguous run of low ones.
module shuf_lane_src
    import shuf_pkg::*;
#(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned LANE  = 0
) (
    input  shuf_mode_e       mode,
    input  logic [IDX_W-1:0] seg_mask,
    input  logic [IDX_W-1:0] operand,
    output logic [IDX_W-1:0] sel,
    output logic             ok
);

    localparam logic [IDX_W-1:0] SELF = IDX_W'(LANE);

    logic [IDX_W:0]   raw_src;
    logic [IDX_W-1:0] seg_base;

    // Start of this lane's aligned segment.
    assign seg_base = SELF & ~seg_mask;

    // Candidate source index per mode, with one extra bit for range escape.
    always_comb begin
        unique case (mode)
            MODE_UP:   raw_src = {1'b0, SELF} - {1'b0, operand};
            MODE_DOWN: raw_src = {1'b0, SELF} + {1'b0, operand};
            MODE_XOR:  raw_src = {1'b0, SELF ^ operand};
            MODE_IDX:  raw_src = {1'b0, seg_base} + {1'b0, operand};
            default:   raw_src = {1'b0, SELF};
        endcase
    end

    // Accept only in-range sources that stay inside the segment; else point at self.
    always_comb begin
        ok  = !raw_src[IDX_W] && ((raw_src[IDX_W-1:0] & ~seg_mask) == seg_base);
        sel = ok ? raw_src[IDX_W-1:0] : SELF;
    end

endmodule

// File: rtl/shuf_xbar.sv
// Module: full crossbar. Each output lane picks one input word by its
// select index. Assumes the selects are already bounded to legal lanes.
module shuf_xbar #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic [LANES*DATA_W-1:0] words_in,
    input  logic [LANES*IDX_W-1:0]  sel_flat,
    output logic [LANES*DATA_W-1:0] words_out
);

    logic [DATA_W-1:0] word_arr [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Unpack the flat input bus into an indexable array.
        assign word_arr[g] = words_in[g*DATA_W +: DATA_W];
        // Each output lane reads the word its select names.
        assign words_out[g*DATA_W +: DATA_W] = word_arr[sel_flat[g*IDX_W +: IDX_W]];
    end

endmodule

// File: rtl/shuf_out_stage.sv
// Module: one register stage with valid/ready. It loads when in_valid and
// out_ready are both high, drops its valid when the consumer takes the
// result and nothing new arrives, and holds while out_ready is low.
// Assumes in_ready is taken as out_ready by the parent.
module shuf_out_stage #(
    parameter int unsigned DW    = 1024,
    parameter int unsigned FLAGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic [DW-1:0]    d_data,
    input  logic [FLAGS-1:0] d_flags,
    output logic             out_valid,
    output logic [DW-1:0]    q_data,
    output logic [FLAGS-1:0] q_flags
);

    // Valid flag: refreshed whenever the consumer side is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (out_ready) begin
            out_valid <= in_valid;
        end
    end

    // Payload: loaded only on an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data  <= '0;
            q_flags <= '0;
        end else if (in_valid && out_ready) begin
            q_data  <= d_data;
            q_flags <= d_flags;
        end
    end

endmodule

// File: rtl/lane_shuffle_unit.sv
// Module: top of the segmented cross-lane shuffle. It decodes the width
// code, computes a source per lane, routes the words through the crossbar
// and registers the result behind a valid/ready stage.
// Assumes inputs are stable while in_valid and out_ready are high.
module lane_shuffle_unit
    import shuf_pkg::*;
#(
    parameter int unsigned N_LANES  = shuf_pkg::LANES,
    parameter int unsigned WORD_W   = shuf_pkg::DATA_W,
    parameter int unsigned CODE_W   = shuf_pkg::WCODE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [1:0]                  mode_sel,
    input  logic [CODE_W-1:0]           width_sel,
    input  logic [$clog2(N_LANES)-1:0]  operand,
    input  logic [N_LANES*WORD_W-1:0]   data_in,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [N_LANES*WORD_W-1:0]   data_out,
    output logic [N_LANES-1:0]          lane_ok
);

    localparam int unsigned LIW   = $clog2(N_LANES);
    localparam int unsigned BUS_W = N_LANES * WORD_W;

    shuf_mode_e             mode;
    logic [LIW-1:0]         seg_mask;
    logic [N_LANES*LIW-1:0] sel_flat;
    logic [N_LANES-1:0]     ok_comb;
    logic [BUS_W-1:0]       routed;
    logic                   fire;

    assign mode     = shuf_mode_e'(mode_sel);
    assign in_ready = out_ready;
    assign fire     = in_valid && out_ready;

    shuf_width_decode #(.IDX_W(LIW), .WCODE_W(CODE_W)) width_i (
        .width_code (width_sel),
        .seg_mask   (seg_mask)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_src
        shuf_lane_src #(.IDX_W(LIW), .LANE(g)) src_i (
            .mode     (mode),
            .seg_mask (seg_mask),
            .operand  (operand),
            .sel      (sel_flat[g*LIW +: LIW]),
            .ok       (ok_comb[g])
        );
    end

    shuf_xbar #(.LANES(N_LANES), .DATA_W(WORD_W), .IDX_W(LIW)) xbar_i (
        .words_in  (data_in),
        .sel_flat  (sel_flat),
        .words_out (routed)
    );

    shuf_out_stage #(.DW(BUS_W), .FLAGS(N_LANES)) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .d_data    (routed),
        .d_flags   (ok_comb),
        .out_valid (out_valid),
        .q_data    (data_out),
        .q_flags   (lane_ok)
    );

    // Handshake properties.
    AST_FIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid); // R2
    AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_ready) |=> !out_valid); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(data_out) && $stable(lane_ok))); // R2

    // Mode and width properties.
    AST_UP_ZERO_ALL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == MODE_UP && operand == '0) |=> (&lane_ok)); // R3
    AST_XOR_BADCODE_ALL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == MODE_XOR && (width_sel == '0 || width_sel > CODE_W'(LIW)))
        |=> (&lane_ok)); // R8

    // A rejected lane returns the word it was given.
    for (genvar g = 0; g < N_LANES; g++) begin : g_chk
        AST_BAD_LANE_SELF: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (lane_ok[g] ||
                      data_out[g*WORD_W +: WORD_W] == $past(data_in[g*WORD_W +: WORD_W]))); // R7
    end

endmodule

// File: tb/lane_shuffle_unit_tb_top.sv
`timescale 1ns/1ps
module lane_shuffle_unit_tb_top;

    localparam int NL = 32;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [1:0]      mode_sel = '0;
    logic [2:0]      width_sel = '0;
    logic [4:0]      operand = '0;
    logic [NL*DW-1:0] data_in = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [NL*DW-1:0] data_out;
    logic [NL-1:0]   lane_ok;

    int total = 0;
    int bad   = 0;

    logic [NL*DW-1:0] q_data [$];
    logic [NL-1:0]    q_ok   [$];
    int               q_mode [$];
    int               q_wsel [$];

    always #10 clk = ~clk;

    lane_shuffle_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode_sel(mode_sel), .width_sel(width_sel), .operand(operand),
        .data_in(data_in), .out_valid(out_valid), .out_ready(out_ready),
        .data_out(data_out), .lane_ok(lane_ok)
    );

    // Behavioural reference: width from code, then a plain integer walk per lane.
    function automatic void ref_model(input logic [NL*DW-1:0] din, input int md,
                                      input int ws, input int op,
                                      output logic [NL*DW-1:0] dout, output logic [NL-1:0] ok);
        int w;
        w = (ws >= 1 && ws <= 5) ? (1 << ws) : 32;
        for (int i = 0; i < NL; i++) begin
            int seg;
            int s;
            seg = (i / w) * w;
            case (md)
                0: s = i - op;
                1: s = i + op;
                2: s = i ^ op;
                default: s = seg + op;
            endcase
            if (s >= seg && s < seg + w) begin
                ok[i] = 1'b1;
                dout[i*DW +: DW] = din[s*DW +: DW];
            end else begin
                ok[i] = 1'b0;
                dout[i*DW +: DW] = din[i*DW +: DW];
            end
        end
    endfunction

    function automatic string tag_of(input logic lane_good, input int md, input int ws);
        if (!lane_good) return "R7";
        if (ws < 1 || ws > 5) return "R8";
        case (md)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One cycle: check what is visible, then drive the next inputs.
    task automatic step(input logic iv, input logic ordy, input int md, input int ws, input int op);
        logic [NL*DW-1:0] ed;
        logic [NL-1:0]    eo;
        @(negedge clk);
        total++;
        if (out_valid !== (q_data.size() != 0)) begin
            bad++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, q_data.size() != 0);
        end
        if (out_valid && q_data.size() != 0) begin
            for (int l = 0; l < NL; l++) begin
                string t;
                t = tag_of(q_ok[0][l], q_mode[0], q_wsel[0]);
                total++;
                if (lane_ok[l] !== q_ok[0][l] || data_out[l*DW +: DW] !== q_data[0][l*DW +: DW]) begin
                    bad++;
                    $display("FAIL %s lane %0d mode %0d wcode %0d actual=%h/%0b expected=%h/%0b",
                             t, l, q_mode[0], q_wsel[0], data_out[l*DW +: DW], lane_ok[l],
                             q_data[0][l*DW +: DW], q_ok[0][l]);
                end
            end
        end
        in_valid  = iv;
        out_ready = ordy;
        mode_sel  = 2'(md);
        width_sel = 3'(ws);
        operand   = 5'(op);
        for (int l = 0; l < NL; l++) data_in[l*DW +: DW] = $urandom;
        #1;
        total++;
        if (in_ready !== ordy) begin
            bad++;
            $display("FAIL R2 in_ready actual=%0b expected=%0b", in_ready, ordy);
        end
        if (ordy && q_data.size() != 0) begin
            void'(q_data.pop_front());
            void'(q_ok.pop_front());
            void'(q_mode.pop_front());
            void'(q_wsel.pop_front());
        end
        if (iv && ordy) begin
            ref_model(data_in, md, ws, op, ed, eo);
            q_data.push_back(ed);
            q_ok.push_back(eo);
            q_mode.push_back(md);
            q_wsel.push_back(ws);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int ops[6] = '{0, 1, 3, 7, 15, 31};
        repeat (4) @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
        end
        rst_n = 1'b1;
        step(0, 1, 0, 5, 0); // R1: stays idle after reset
        // Directed sweep: every mode, every width code (R8 illegal codes included).
        for (int md = 0; md < 4; md++)
            for (int ws = 0; ws < 8; ws++) begin
                for (int k = 0; k < 6; k++) step(1, 1, md, ws, ops[k]);
                step(1, 1, md, ws, int'($urandom_range(0, 31)));
            end
        // Stall and drain patterns (R2).
        step(1, 1, 2, 2, 1);
        step(1, 0, 0, 3, 5);
        step(1, 0, 1, 3, 5);
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        // Random traffic with random stalls.
        for (int n = 0; n < 3000; n++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 31)));
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule